// File: doc/BRIEF.md
# Bit-field extract and mask ALU

This execution unit sits in a processor datapath and evaluates one of ten single-operand bit operations on a 32-bit source value. One operation pulls a contiguous field out of the operand, steered by a 16-bit control word that carries a start position and a length. The other nine build masks by combining the operand with its value plus one or minus one. Typical uses are isolating the lowest set or clear bit, filling trailing zeros or ones, and building trailing-bit masks.

The caller presents a valid strobe, a 4-bit operation code, the operand and the control word in one cycle. One clock later the unit returns the 32-bit result and six status flags (overflow, sign, zero, auxiliary, parity, carry), qualified by an output valid strobe. The carry flag reports the increment or decrement wrap-around, not anything derived from the result. Unused operation codes return zero with every flag cleared.

Top module: `bitmask_alu`

## Requirements
- R1: The outputs are registered. `out_valid` is high in the cycle after `in_valid` was high, and low otherwise. A low `rst_n` at a clock edge clears `out_valid`.
- R2: Extract (op code 0) uses control bits [7:0] as the start position and bits [15:8] as the length. It returns zero when the start position is 32 or more, or when the length is zero.
- R3: Otherwise extract returns the operand shifted right by the start position. When the length is below 32, only the low `length` bits are kept. A length of 32 or more leaves the shifted value unmasked.
- R4: Increment-based codes return these results: 1 = (x+1)&x, 2 = ~(x+1)|x, 3 = (x+1)&~x, 4 = (x+1)^x, 5 = (x+1)|x, 6 = (x+1)|~x. All arithmetic is modulo 2^32.
- R5: Decrement-based codes return these results: 7 = (x-1)|x, 8 = (x-1)|~x, 9 = (x-1)&~x. All arithmetic is modulo 2^32.
- R6: For codes 1 to 6, the carry flag is set exactly when x is all ones.
- R7: For codes 7 to 9, the carry flag is set exactly when x is zero.
- R8: The overflow and auxiliary flags are always clear. Extract always clears the carry flag.
- R9: For codes 0 to 9, the sign flag equals result bit 31, the zero flag is set when the result is zero, and the parity flag is set when result bits [7:0] contain an even number of ones.
- R10: Codes 10 to 15 return a zero result with all six flags clear, including the zero flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_op | input | 4 | Operation code |
| in_src | input | 32 | Source operand |
| in_ctrl | input | 16 | Extract control: start in [7:0], length in [15:8] |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 32 | Operation result |
| out_of | output | 1 | Overflow flag |
| out_sf | output | 1 | Sign flag |
| out_zf | output | 1 | Zero flag |
| out_af | output | 1 | Auxiliary flag |
| out_pf | output | 1 | Parity flag |
| out_cf | output | 1 | Carry flag (increment/decrement wrap) |

## Verification
The bench builds the unit with its default widths: a 32-bit operand and a 16-bit control word split into two 8-bit fields. At these widths, start positions from 32 up to 255 and lengths from 32 up to 255 are reachable. This exercises both the out-of-range zeroing and the unmasked long-field path. Both operand wrap points, all ones and zero, sit inside the 32-bit range and are driven directly, as are every defined code and several unused ones.

// File: rtl/bmalu_pkg.sv
package bmalu_pkg;

  typedef enum logic [3:0] {
    OP_EXTRACT   = 4'd0,
    OP_INC_AND   = 4'd1,
    OP_INC_NOTOR = 4'd2,
    OP_INC_ANDN  = 4'd3,
    OP_INC_XOR   = 4'd4,
    OP_INC_OR    = 4'd5,
    OP_INC_ORN   = 4'd6,
    OP_DEC_OR    = 4'd7,
    OP_DEC_ORN   = 4'd8,
    OP_DEC_ANDN  = 4'd9
  } op_e;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } flags_t;

  function automatic logic op_is_inc(logic [3:0] op);
    return (op >= OP_INC_AND) && (op <= OP_INC_ORN);
  endfunction

  function automatic logic op_is_dec(logic [3:0] op);
    return (op >= OP_DEC_OR) && (op <= OP_DEC_ANDN);
  endfunction

  function automatic logic op_is_known(logic [3:0] op);
    return op <= OP_DEC_ANDN;
  endfunction

  function automatic logic even_ones8(logic [7:0] b);
    return ~^b;
  endfunction

endpackage

// File: rtl/field_extract.sv
module field_extract #(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 16
) (
  input  logic [DATA_W-1:0] src,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [DATA_W-1:0] field,
  output logic              zeroed
);
  localparam int HALF_W = CTRL_W / 2;

  logic [HALF_W-1:0] start_pos;
  logic [HALF_W-1:0] field_len;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] keep;

  assign start_pos = ctrl[HALF_W-1:0];
  assign field_len = ctrl[CTRL_W-1:HALF_W];

  // start beyond the word or empty field forces a zero result
  assign zeroed  = (int'(start_pos) >= DATA_W) || (field_len == '0);
  assign shifted = src >> start_pos;

  // bit g survives when the field is longer than g; lengths past the
  // word width therefore keep every bit
  for (genvar g = 0; g < DATA_W; g++) begin : g_keep
    assign keep[g] = int'(field_len) > g;
  end

  assign field = zeroed ? '0 : (shifted & keep);
endmodule

// File: rtl/mask_gen.sv
module mask_gen
  import bmalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] x,
  output logic [DATA_W-1:0] res,
  output logic              wrap
);
  logic [DATA_W-1:0] x_inc;
  logic [DATA_W-1:0] x_dec;
  logic              inc_carry;
  logic              dec_borrow;

  assign {inc_carry, x_inc}  = {1'b0, x} + {{DATA_W{1'b0}}, 1'b1};
  assign {dec_borrow, x_dec} = {1'b0, x} - {{DATA_W{1'b0}}, 1'b1};

  always_comb begin
    unique case (op)
      OP_INC_AND:   res = x_inc & x;
      OP_INC_NOTOR: res = ~x_inc | x;
      OP_INC_ANDN:  res = x_inc & ~x;
      OP_INC_XOR:   res = x_inc ^ x;
      OP_INC_OR:    res = x_inc | x;
      OP_INC_ORN:   res = x_inc | ~x;
      OP_DEC_OR:    res = x_dec | x;
      OP_DEC_ORN:   res = x_dec | ~x;
      OP_DEC_ANDN:  res = x_dec & ~x;
      default:      res = '0;
    endcase
  end

  // carry reports the arithmetic wrap, never the logic result
  assign wrap = op_is_inc(op) ? inc_carry :
                op_is_dec(op) ? dec_borrow : 1'b0;
endmodule

// File: rtl/flag_gen.sv
module flag_gen
  import bmalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res,
  input  logic              cf_in,
  output flags_t            flags
);
  always_comb begin
    flags.of = 1'b0;
    flags.af = 1'b0;
    flags.sf = res[DATA_W-1];
    flags.zf = (res == '0);
    flags.pf = even_ones8(res[7:0]);
    flags.cf = cf_in;
  end
endmodule

// File: rtl/bitmask_alu.sv
module bitmask_alu
  import bmalu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        in_op,
  input  logic [DATA_W-1:0] in_src,
  input  logic [CTRL_W-1:0] in_ctrl,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_of,
  output logic              out_sf,
  output logic              out_zf,
  output logic              out_af,
  output logic              out_pf,
  output logic              out_cf
);
  localparam int HALF_W = CTRL_W / 2;

  logic [DATA_W-1:0] ext_field;
  logic              ext_zeroed;
  logic [DATA_W-1:0] mask_res;
  logic              mask_wrap;
  logic [DATA_W-1:0] sel_res;
  logic              sel_cf;
  logic              op_known;
  flags_t            raw_flags;
  flags_t            next_flags;
  flags_t            flags_q;

  field_extract #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_extract (
    .src   (in_src),
    .ctrl  (in_ctrl),
    .field (ext_field),
    .zeroed(ext_zeroed)
  );

  mask_gen #(.DATA_W(DATA_W)) u_mask (
    .op  (in_op),
    .x   (in_src),
    .res (mask_res),
    .wrap(mask_wrap)
  );

  assign op_known = op_is_known(in_op);

  always_comb begin
    if (in_op == OP_EXTRACT) begin
      sel_res = ext_field;
      sel_cf  = 1'b0;
    end else if (op_known) begin
      sel_res = mask_res;
      sel_cf  = mask_wrap;
    end else begin
      sel_res = '0;
      sel_cf  = 1'b0;
    end
  end

  flag_gen #(.DATA_W(DATA_W)) u_flags (
    .res  (sel_res),
    .cf_in(sel_cf),
    .flags(raw_flags)
  );

  assign next_flags = op_known ? raw_flags : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      flags_q    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= sel_res;
        flags_q    <= next_flags;
      end
    end
  end

  assign out_of = flags_q.of;
  assign out_sf = flags_q.sf;
  assign out_zf = flags_q.zf;
  assign out_af = flags_q.af;
  assign out_pf = flags_q.pf;
  assign out_cf = flags_q.cf;

  // ---------------- assertions ----------------
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_extract_oob_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_EXTRACT && int'(in_ctrl[HALF_W-1:0]) >= DATA_W)
      |=> (out_result == '0));

  // an extracted field can only contain bits present in the shifted operand
  assert_extract_subset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_EXTRACT)
      |=> ((out_result & ~($past(in_src) >> $past(in_ctrl[HALF_W-1:0]))) == '0));

  // x ^ (x+1) always has bit 0 set
  assert_inc_xor_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_INC_XOR) |=> out_result[0]);

  assert_inc_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_is_inc(in_op)) |=> (out_cf == ($past(in_src) == '1)));
  assert_dec_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_is_dec(in_op)) |=> (out_cf == ($past(in_src) == '0)));

  assert_of_af_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!out_of && !out_af));

  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_known) |=> (out_zf == (out_result == '0)));
  assert_sign_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sf == out_result[DATA_W-1]));

  assert_unused_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_known)
      |=> (out_result == '0 && !out_cf && !out_zf && !out_pf && !out_sf));
endmodule

// File: tb/sim_bitmask_alu.sv
module sim_bitmask_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  in_op;
  logic [31:0] in_src;
  logic [15:0] in_ctrl;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_of, out_sf, out_zf, out_af, out_pf, out_cf;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bitmask_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_src(in_src), .in_ctrl(in_ctrl), .out_valid(out_valid),
    .out_result(out_result), .out_of(out_of), .out_sf(out_sf),
    .out_zf(out_zf), .out_af(out_af), .out_pf(out_pf), .out_cf(out_cf)
  );

  // ---------- behavioural reference ----------
  function automatic logic [31:0] model_result(int op, logic [31:0] x, logic [15:0] c);
    longint xl = longint'(x);
    logic [31:0] up = 32'((xl + 1) % 64'h1_0000_0000);
    logic [31:0] dn = 32'((xl + 64'hFFFF_FFFF) % 64'h1_0000_0000);
    logic [31:0] r = '0;
    int st = int'(c[7:0]);
    int ln = int'(c[15:8]);
    case (op)
      0: for (int i = 0; i < 32; i++)
           if (i < ln && st + i < 32) r[i] = x[st + i];
      1: r = up & x;
      2: r = ~up | x;
      3: r = up & ~x;
      4: r = up ^ x;
      5: r = up | x;
      6: r = up | ~x;
      7: r = dn | x;
      8: r = dn | ~x;
      9: r = dn & ~x;
      default: r = '0;
    endcase
    return r;
  endfunction

  // flags packed as {of, sf, zf, af, pf, cf}
  function automatic logic [5:0] model_flags(int op, logic [31:0] x, logic [31:0] r);
    int ones = 0;
    logic cf = 1'b0;
    if (op > 9) return 6'b0;
    for (int i = 0; i < 8; i++) ones += int'(r[i]);
    if (op >= 1 && op <= 6) cf = (x == 32'hFFFF_FFFF);
    if (op >= 7) cf = (x == 32'h0);
    return {1'b0, r[31], (r == 0), 1'b0, (ones % 2 == 0), cf};
  endfunction

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // one request per cycle; compare on the following edge
  task automatic issue(string req, bit v, int op, logic [31:0] x, logic [15:0] c);
    logic [31:0] er;
    logic [5:0]  ef;
    @(negedge clk);
    in_valid = v;
    in_op    = 4'(op);
    in_src   = x;
    in_ctrl  = c;
    er = model_result(op, x, c);
    ef = model_flags(op, x, er);
    @(posedge clk);
    #1;
    check(req, "valid", {31'b0, out_valid}, {31'b0, v});
    if (v) begin
      check(req, "result", out_result, er);
      check(req, "flags", {26'b0, out_of, out_sf, out_zf, out_af, out_pf, out_cf},
            {26'b0, ef});
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b1; in_op = 4'd0; in_src = '0; in_ctrl = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset valid", {31'b0, out_valid}, 32'b0);
    @(negedge clk);
    rst_n = 1'b1; in_valid = 1'b0;

    // R1: strobe timing, including a gap
    issue("R1", 1, 4, 32'h0000_00FF, 16'h0);
    issue("R1", 0, 4, 32'h1234_5678, 16'h0);
    issue("R1", 1, 5, 32'h0F0F_0F0F, 16'h0);

    // R2: out-of-range start, empty field
    issue("R2", 1, 0, 32'hFFFF_FFFF, 16'h0820);
    issue("R2", 1, 0, 32'hFFFF_FFFF, 16'hFFFF);
    issue("R2", 1, 0, 32'hDEAD_BEEF, 16'h0004);
    issue("R2", 1, 0, 32'hDEAD_BEEF, 16'h0400);

    // R3: masked and unmasked fields
    issue("R3", 1, 0, 32'hDEAD_BEEF, 16'h0804);
    issue("R3", 1, 0, 32'hDEAD_BEEF, 16'h1F00);
    issue("R3", 1, 0, 32'hDEAD_BEEF, 16'h2000);
    issue("R3", 1, 0, 32'hDEAD_BEEF, 16'hFF10);
    issue("R3", 1, 0, 32'h8000_0000, 16'h011F);

    // R4 and R6: increment family over patterns incl. all ones
    for (int op = 1; op <= 6; op++) begin
      issue("R4", 1, op, 32'h0000_0057, 16'h0);
      issue("R4", 1, op, 32'h8000_FFFF, 16'h0);
      issue("R6", 1, op, 32'hFFFF_FFFF, 16'h0);
      issue("R6", 1, op, 32'h0, 16'h0);
    end

    // R5 and R7: decrement family incl. zero
    for (int op = 7; op <= 9; op++) begin
      issue("R5", 1, op, 32'h0000_0A80, 16'h0);
      issue("R5", 1, op, 32'hFFFF_FFFF, 16'h0);
      issue("R7", 1, op, 32'h0, 16'h0);
      issue("R7", 1, op, 32'h8000_0000, 16'h0);
    end

    // R8: extract carry stays clear on an all-ones operand
    issue("R8", 1, 0, 32'hFFFF_FFFF, 16'h2000);

    // R9: sign, zero and parity corners
    issue("R9", 1, 1, 32'h7FFF_FFFF, 16'h0);
    issue("R9", 1, 0, 32'h0000_0003, 16'h0800);
    issue("R9", 1, 0, 32'h0000_0007, 16'h0800);

    // R10: unused codes
    for (int op = 10; op <= 15; op++)
      issue("R10", 1, op, 32'hFFFF_FFFF, 16'h0810);

    // mixed sweep across all codes
    for (int k = 0; k < 400; k++)
      issue("R4", 1, int'($urandom_range(0, 15)), $urandom, 16'($urandom));

    finish_run();
  end
endmodule